// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the logic core of a small programmable logic device. Eight dedicated inputs and eight feedback signals are each offered to the array in true and inverted form, giving 32 array lines. Sixty-four programmable product terms each form the AND of whichever lines are connected to them. A connection map of 64 rows by 32 bits records which line reaches which term. The terms are split by output cell: seven terms per cell are ORed into that cell's sum, and an eighth term per cell is brought out on its own. Downstream output logic can use that eighth term as an additional sum input or as an enable.

The connection map is loaded one row at a time through a program port. A small controller with three states governs the port. In `ST_RUN` the port ignores all writes. In `ST_PROG` row writes are accepted. `ST_ERASE` lasts one cycle and opens every connection at its closing edge. The named transitions are:
- *enter* (`ST_RUN`→`ST_PROG`, taken when `prog_en` is high at an edge);
- *leave* (`ST_PROG`→`ST_RUN`, taken when `prog_en` is low);
- *erase* (`ST_PROG`→`ST_ERASE`, taken when `prog_en` and `prog_erase` are both high);
- *resume* (`ST_ERASE`→`ST_PROG`, taken if `prog_en` is still high);
- *abort* (`ST_ERASE`→`ST_RUN`, taken otherwise).

The array outputs are combinational from the inputs and the current map. They are meaningful only when `prog_en` is low.

Top module: `sop_logic_array`

## Requirements
- R1: While reset is asserted, and after it is released, every connection is open, so `or_sum` and `xtra_term` read all ones whatever the inputs.
- R2: Array line 2k is `ded_in[k]` and line 2k+1 is its inverse (k = 0..7). Line 16+2k is `fb_in[k]` and line 17+2k is its inverse.
- R3: A product term is the AND of every line whose map bit is 1 (connected). A term whose 32 bits are all 0 (open) is true.
- R4: A term that connects both the true and the inverted line of the same signal is always false.
- R5: Map row 8c+i (i = 0..6) feeds the OR that drives `or_sum[c]`. Row 8c+7 drives `xtra_term[c]` directly.
- R6: In `ST_PROG`, when `prog_en` and `prog_wr` are both high at a clock edge, row `prog_row` takes `prog_data`, with bit j governing line j. The new row is visible after that edge.
- R7: Writes have no effect when `prog_en` is low. They also have no effect in the edge that takes the controller from `ST_RUN` into `ST_PROG`.
- R8: `prog_erase` in `ST_PROG` enters `ST_ERASE` for exactly one cycle. At the end of that cycle every connection is open. A write during that cycle is lost.
- R9: The controller moves only along the enter, leave, erase, resume and abort transitions. An erase occurs only after `prog_en` and `prog_erase` were both high on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the map and the controller |
| rst_n | input | 1 | Asynchronous active-low reset; opens the whole map |
| ded_in | input | 8 | Dedicated input signals |
| fb_in | input | 8 | Feedback or pin signals |
| prog_en | input | 1 | Programming session enable |
| prog_erase | input | 1 | Bulk erase request |
| prog_wr | input | 1 | Row write strobe |
| prog_row | input | 6 | Row address for a write |
| prog_data | input | 32 | Row contents, 1 = connected |
| or_sum | output | 8 | Per-cell OR of its seven terms |
| xtra_term | output | 8 | Per-cell extra product term |

## Verification
After erase or reset every term is true, so an OR sum can only fall when all seven of its terms are false at once. That state is hard to reach from the ports. The bench first fills whole groups with rows that connect both polarities of one input. Only after that does it give single rows real conditions, so that each `or_sum` bit follows one term. The bench also programs sparse random rows with about four connections each, so that a fair share of terms are true for some input patterns. Two cases need exact edge placement: a write issued in the edge where `prog_en` first rises, and a write landing in the erase cycle. The bench reaches both by aligning the strobes to those edges, and a reference map that is updated every clock confirms that both writes are ignored.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } prog_state_e;

endpackage

// File: rtl/sop_prog_ctrl.sv
module sop_prog_ctrl
    import sop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prog_en,
    input  logic prog_erase,
    input  logic prog_wr,
    output logic wr_en,
    output logic clr_en
);

    prog_state_e st_q;
    prog_state_e st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (prog_en) st_d = ST_PROG;          // enter
            end
            ST_PROG: begin
                if (!prog_en)        st_d = ST_RUN;   // leave
                else if (prog_erase) st_d = ST_ERASE; // erase
            end
            ST_ERASE: begin
                st_d = prog_en ? ST_PROG : ST_RUN;    // resume / abort
            end
            default: st_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        wr_en  = 1'b0;
        clr_en = 1'b0;
        unique case (st_q)
            ST_RUN:   ;
            ST_PROG:  wr_en  = prog_en && prog_wr;
            ST_ERASE: clr_en = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/sop_fuse_store.sv
module sop_fuse_store #(
    parameter int ROWS  = 64,
    parameter int LINES = 32,
    parameter int AW    = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        clr_en,
    input  logic [AW-1:0]               wr_row,
    input  logic [LINES-1:0]            wr_data,
    output logic [ROWS-1:0][LINES-1:0]  fuse_map
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [LINES-1:0] row_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q <= '0;
            end else if (clr_en) begin
                row_q <= '0;
            end else if (wr_en && (wr_row == AW'(r))) begin
                row_q <= wr_data;
            end
        end
        assign fuse_map[r] = row_q;
    end

endmodule

// File: rtl/sop_line_builder.sv
module sop_line_builder #(
    parameter int N_DED = 8,
    parameter int N_FB  = 8,
    localparam int LINES = 2 * (N_DED + N_FB)
) (
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_FB-1:0]  fb_in,
    output logic [LINES-1:0] lines
);

    for (genvar k = 0; k < N_DED; k++) begin : g_ded
        assign lines[2*k]     = ded_in[k];
        assign lines[2*k + 1] = ~ded_in[k];
    end

    for (genvar k = 0; k < N_FB; k++) begin : g_fb
        assign lines[2*N_DED + 2*k]     = fb_in[k];
        assign lines[2*N_DED + 2*k + 1] = ~fb_in[k];
    end

endmodule

// File: rtl/sop_term_eval.sv
module sop_term_eval #(
    parameter int ROWS  = 64,
    parameter int LINES = 32
) (
    input  logic [ROWS-1:0][LINES-1:0] fuse_map,
    input  logic [LINES-1:0]           lines,
    output logic [ROWS-1:0]            terms
);

    // an open cell passes 1; a connected cell passes its line
    for (genvar t = 0; t < ROWS; t++) begin : g_term
        assign terms[t] = &(~fuse_map[t] | lines);
    end

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array #(
    parameter int N_DED     = 8,
    parameter int N_FB      = 8,
    parameter int N_CELLS   = 8,
    parameter int SUM_TERMS = 7,
    localparam int ROWS_PER_CELL = SUM_TERMS + 1,
    localparam int ROWS          = N_CELLS * ROWS_PER_CELL,
    localparam int LINES         = 2 * (N_DED + N_FB),
    localparam int ROW_AW        = $clog2(ROWS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_DED-1:0]   ded_in,
    input  logic [N_FB-1:0]    fb_in,
    input  logic               prog_en,
    input  logic               prog_erase,
    input  logic               prog_wr,
    input  logic [ROW_AW-1:0]  prog_row,
    input  logic [LINES-1:0]   prog_data,
    output logic [N_CELLS-1:0] or_sum,
    output logic [N_CELLS-1:0] xtra_term
);

    logic                       wr_en;
    logic                       clr_en;
    logic [ROWS-1:0][LINES-1:0] fuse_map;
    logic [LINES-1:0]           lines;
    logic [ROWS-1:0]            terms;

    sop_prog_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_en    (prog_en),
        .prog_erase (prog_erase),
        .prog_wr    (prog_wr),
        .wr_en      (wr_en),
        .clr_en     (clr_en)
    );

    sop_fuse_store #(
        .ROWS  (ROWS),
        .LINES (LINES),
        .AW    (ROW_AW)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .clr_en   (clr_en),
        .wr_row   (prog_row),
        .wr_data  (prog_data),
        .fuse_map (fuse_map)
    );

    sop_line_builder #(
        .N_DED (N_DED),
        .N_FB  (N_FB)
    ) i_lines (
        .ded_in (ded_in),
        .fb_in  (fb_in),
        .lines  (lines)
    );

    sop_term_eval #(
        .ROWS  (ROWS),
        .LINES (LINES)
    ) i_terms (
        .fuse_map (fuse_map),
        .lines    (lines),
        .terms    (terms)
    );

    for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
        assign or_sum[c]    = |terms[c*ROWS_PER_CELL +: SUM_TERMS];
        assign xtra_term[c] = terms[c*ROWS_PER_CELL + SUM_TERMS];
    end

endmodule

// File: rtl/sop_logic_array_chk.sv
module sop_logic_array_chk #(
    parameter int ROWS    = 64,
    parameter int LINES   = 32,
    parameter int N_CELLS = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       prog_en,
    input logic                       prog_erase,
    input logic                       wr_en,
    input logic                       clr_en,
    input logic [ROWS-1:0][LINES-1:0] fuse_map,
    input logic [N_CELLS-1:0]         or_sum,
    input logic [N_CELLS-1:0]         xtra_term
);

    // after an erase cycle every term is true
    p_erase_opens_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((&or_sum) && (&xtra_term)));

    p_erase_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !clr_en);

    p_idle_map_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_en && !clr_en) |=> $stable(fuse_map));

    p_erase_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> $past(prog_en && prog_erase));

    p_wr_clr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr_en));

endmodule

bind sop_logic_array sop_logic_array_chk #(
    .ROWS    (ROWS),
    .LINES   (LINES),
    .N_CELLS (N_CELLS)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_en    (prog_en),
    .prog_erase (prog_erase),
    .wr_en      (wr_en),
    .clr_en     (clr_en),
    .fuse_map   (fuse_map),
    .or_sum     (or_sum),
    .xtra_term  (xtra_term)
);

// File: tb/test_sop_logic_array.sv
`timescale 1ns/1ps
module test_sop_logic_array;

    localparam int NROW = 64;
    localparam int NCEL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ded_in = '0;
    logic [7:0]  fb_in = '0;
    logic        prog_en = 1'b0;
    logic        prog_erase = 1'b0;
    logic        prog_wr = 1'b0;
    logic [5:0]  prog_row = '0;
    logic [31:0] prog_data = '0;
    logic [7:0]  or_sum;
    logic [7:0]  xtra_term;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    sop_logic_array i_sop_logic_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .ded_in     (ded_in),
        .fb_in      (fb_in),
        .prog_en    (prog_en),
        .prog_erase (prog_erase),
        .prog_wr    (prog_wr),
        .prog_row   (prog_row),
        .prog_data  (prog_data),
        .or_sum     (or_sum),
        .xtra_term  (xtra_term)
    );

    // ---------------- reference model ----------------
    bit [31:0] fm [NROW];
    int        mst = 0;   // 0 idle, 1 programming, 2 erasing

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NROW; r++) fm[r] = '0;
            mst = 0;
        end else begin
            case (mst)
                0: if (prog_en) mst = 1;
                1: begin
                    if (prog_en && prog_wr) fm[prog_row] = prog_data;
                    if (!prog_en) mst = 0;
                    else if (prog_erase) mst = 2;
                end
                default: begin
                    for (int r = 0; r < NROW; r++) fm[r] = '0;
                    mst = prog_en ? 1 : 0;
                end
            endcase
        end
    end

    function automatic bit line_val(int j);
        if (j < 16) return (j % 2 == 0) ? ded_in[j/2] : ~ded_in[j/2];
        return (j % 2 == 0) ? fb_in[(j-16)/2] : ~fb_in[(j-16)/2];
    endfunction

    function automatic bit [15:0] model_out();
        bit [7:0] s = '0;
        bit [7:0] x = '0;
        for (int t = 0; t < NROW; t++) begin
            bit p = 1'b1;
            for (int j = 0; j < 32; j++)
                if (fm[t][j] && !line_val(j)) p = 1'b0;
            if (t % 8 == 7) x[t/8] = p;
            else if (p) s[t/8] = 1'b1;
        end
        return {x, s};
    endfunction

    // ---------------- stimulus helpers ----------------
    task automatic step(input logic [7:0] d, input logic [7:0] f,
                        input logic pe, input logic er, input logic w,
                        input logic [5:0] row, input logic [31:0] dat,
                        input string req);
        bit [15:0] exp;
        @(negedge clk);
        ded_in = d; fb_in = f; prog_en = pe; prog_erase = er;
        prog_wr = w; prog_row = row; prog_data = dat;
        #1;
        exp = model_out();
        total++;
        if ({xtra_term, or_sum} !== exp) begin
            bad++;
            $display("FAIL %s: xtra/or actual=%h expected=%h", req,
                     {xtra_term, or_sum}, exp);
        end
    endtask

    task automatic idle_eval(int n, input string req);
        for (int i = 0; i < n; i++)
            step($urandom, $urandom, 1'b0, 1'b0, 1'b0, '0, '0, req);
    endtask

    task automatic wr_row(input logic [5:0] row, input logic [31:0] dat,
                          input string req);
        step($urandom, $urandom, 1'b1, 1'b0, 1'b1, row, dat, req);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state, all open
        for (int i = 0; i < 3; i++)
            step($urandom, $urandom, 1'b0, 1'b0, 1'b0, '0, '0, "R1");
        @(negedge clk); rst_n = 1'b1;
        idle_eval(4, "R1");
        // R3: erased array, all terms true
        idle_eval(6, "R3");

        // R7: write on the entering edge is dropped
        step(8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 6'd7, 32'h1, "R7");
        step(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, '0, '0, "R7");
        // R4: group 0 rows hold both polarities of ded_in[0]
        for (int r = 0; r < 7; r++) wr_row(6'(r), 32'h0000_0003, "R4");
        // R2: row 7 tests ded_in[0] true, row 15 tests fb_in[3] inverted
        wr_row(6'd7, 32'h0000_0001, "R2");
        wr_row(6'd15, 32'h0080_0000, "R2");
        idle_eval(8, "R4");
        // R5: row 0 now follows inverse of fb_in[0]
        step(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, '0, '0, "R6");
        wr_row(6'd0, 32'h0002_0000, "R6");
        idle_eval(8, "R5");
        step(8'h01, 8'h00, 1'b0, 1'b0, 1'b0, '0, '0, "R2");
        step(8'h00, 8'h09, 1'b0, 1'b0, 1'b0, '0, '0, "R2");
        // R7: writes with prog_en low are ignored
        step(8'h00, 8'h01, 1'b0, 1'b0, 1'b1, 6'd1, 32'h0, "R7");
        step(8'h00, 8'h01, 1'b0, 1'b0, 1'b1, 6'd2, 32'h0, "R7");
        idle_eval(4, "R7");

        // R6/R5: random sparse maps
        for (int rep = 0; rep < 4; rep++) begin
            step(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, '0, '0, "R9");
            for (int r = 0; r < NROW; r++)
                wr_row(6'(r), $urandom & $urandom & $urandom, "R6");
            idle_eval(40, "R5");
        end

        // R8: erase, write during erase cycle lost
        step(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, '0, '0, "R8");
        step(8'h00, 8'h00, 1'b1, 1'b1, 1'b0, '0, '0, "R8");
        step(8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 6'd3, 32'h0000_0003, "R8");
        step(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, '0, '0, "R8");
        idle_eval(6, "R8");
        // R9: resume after erase accepts writes
        step(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, '0, '0, "R9");
        step(8'h00, 8'h00, 1'b1, 1'b1, 1'b0, '0, '0, "R9");
        step(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, '0, '0, "R9");
        wr_row(6'd23, 32'h0000_0300, "R9");
        idle_eval(6, "R9");
        // R9: abort path, prog_en dropped during erase
        step(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, '0, '0, "R9");
        wr_row(6'd31, 32'h0000_0004, "R9");
        step(8'h00, 8'h00, 1'b1, 1'b1, 1'b0, '0, '0, "R9");
        step(8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 6'd31, 32'h3, "R9");
        step(8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 6'd31, 32'h3, "R9");
        idle_eval(6, "R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule